// File: doc/BRIEF.md
# Element Failure Detection Latch

This block watches one digital comparator bit per antenna element and builds a registered record of which elements have failed. A bit at 1 means that element's sampled drive level has dropped to or below its failure threshold; 0 means healthy. Each bit first crosses a two-flop synchronizer. It then has to stay high for a programmable number of consecutive cycles before it counts as a failure, so short glitches are filtered out.

Failures are accepted strictly one at a time. When one is accepted, the block emits a one-cycle `fail_valid` pulse that starts pattern recovery, and drives the element's binary index on `fail_idx`. It sets the element's bit in a sticky exclusion mask and appends the index to an internal failure log. From then on the masked element is ignored, so only the remaining healthy elements can raise a new failure. If several unmasked elements qualify at once, the lowest index goes first and the others follow on the next cycles, one per cycle.

The controller is a two-state machine. `ST_WATCH` accepts qualified failures. `ST_FULL` is entered when the failure count reaches N, and accepts nothing more. The transition `WATCH->FULL` fires on the accept that brings the count to N. `FULL->WATCH` and `WATCH->WATCH` (clear) fire on the synchronous `clr`, which empties the mask, the count and the log.

Top module: `fail_latch_top`

## Requirements
- R1: After reset, `fail_valid`, `fail_idx`, `fail_mask`, `fail_count` and `fail_log` are all zero.
- R2: A comparator bit driven high before clock edge E0 and held high gives `fail_valid` right after edge E0+H+1, where H is `hold_len` (a value of 0 acts as 1). That edge is the H+2-th edge counting E0 as the first.
- R3: A comparator bit that is high for fewer than H consecutive cycles is never reported.
- R4: `fail_valid` lasts one cycle per accepted failure. While it is high, `fail_idx` is the binary number of the failed element (input bit i gives index i).
- R5: When several unmasked elements qualify in the same cycle, they are reported lowest index first, on consecutive cycles, one per cycle.
- R6: Bit i of `fail_mask` becomes 1 on the same edge that reports element i, and stays 1 until `clr` or reset.
- R7: A masked element's comparator bit has no effect: toggling it gives no `fail_valid`, and the mask, count and log do not change.
- R8: `fail_count` rises by one per reported failure and saturates at N. Once it equals N, no further failure is reported.
- R9: Log slot k (`fail_log` bits k*IW upward, IW index bits wide) holds the index of the k-th reported failure, counting from 0.
- R10: Holding `clr` high for one cycle clears the mask, the count and the log on the next edge. An element whose bit is still high afterwards is detected again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of mask, count and log |
| hold_len | input | CW | Cycles a bit must stay high to qualify (0 acts as 1) |
| comp_in | input | N | Raw comparator bits, 1 = failed |
| fail_valid | output | 1 | One-cycle pulse per accepted failure |
| fail_idx | output | IW | Index of the element just accepted |
| fail_mask | output | N | Sticky mask of logged elements |
| fail_count | output | KW | Number of logged failures, saturating at N |
| fail_log | output | N*IW | Indices of failures in order of detection |

## Verification
The bench measures the exact edge of the first report. A synchronizer stage that is missing, or an off-by-one in the persistence counter, moves that edge and is caught. It drives a pulse one cycle shorter than the hold length; a filter that compares with the wrong bound reports it. Three elements rising together must come out as indices in ascending order on back-to-back cycles; a wrong priority, or an encoder that sees the stale mask, would repeat an index or reorder them. Finally the bench toggles an already-masked element, fills every element to hit saturation, and clears with an input still high. A mask that is not sticky re-triggers, a count that wraps shows zero, and a clear that misses the log leaves old indices behind.

// File: rtl/fail_latch_pkg.sv
package fail_latch_pkg;
    typedef enum logic [0:0] {
        ST_WATCH = 1'b0,
        ST_FULL  = 1'b1
    } fl_state_t;
endpackage

// File: rtl/fail_sync.sv
module fail_sync #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] synced
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic stage1, stage2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1 <= 1'b0;
                stage2 <= 1'b0;
            end else begin
                stage1 <= raw[i];
                stage2 <= stage1;
            end
        end
        assign synced[i] = stage2;
    end
endmodule

// File: rtl/fail_qualify.sv
module fail_qualify #(
    parameter int N  = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [CW-1:0] hold_len,
    input  logic [N-1:0]  level,
    input  logic [N-1:0]  excluded,
    output logic [N-1:0]  qualified
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    logic [CW:0] need;
    always_comb need = (hold_len == '0) ? {{CW{1'b0}}, 1'b1} : {1'b0, hold_len};

    for (genvar i = 0; i < N; i++) begin : g_cnt
        logic [CW-1:0] run_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                run_q <= '0;
            end else if (clr || excluded[i] || !level[i]) begin
                run_q <= '0;
            end else if (run_q != CNT_MAX) begin
                run_q <= run_q + 1'b1;
            end
        end
        assign qualified[i] = level[i] && !excluded[i] &&
                              (({1'b0, run_q} + 1'b1) >= need);

        // R7
        excl_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
            excluded[i] |-> !qualified[i]);
    end
endmodule

// File: rtl/fail_pick.sv
module fail_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    logic [N-1:0] grant;

    always_comb begin
        grant = req & (~req + 1'b1);
        found = |req;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx = IW'(i);
        end
    end

    // R5
    always_comb pick_onehot_chk: assert ($onehot0(grant));
endmodule

// File: rtl/fail_latch_top.sv
module fail_latch_top
    import fail_latch_pkg::*;
#(
    parameter int N  = 8,
    parameter int CW = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1,
    localparam int KW = $clog2(N + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic [CW-1:0]   hold_len,
    input  logic [N-1:0]    comp_in,
    output logic            fail_valid,
    output logic [IW-1:0]   fail_idx,
    output logic [N-1:0]    fail_mask,
    output logic [KW-1:0]   fail_count,
    output logic [N*IW-1:0] fail_log
);
    localparam logic [KW-1:0] FULL_CNT = KW'(N);

    fl_state_t     state_q, state_d;
    logic [N-1:0]  level, qualified;
    logic          found;
    logic [IW-1:0] pick_idx;
    logic          accept;
    logic [IW-1:0] log_q [N];

    fail_sync #(.N(N)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw(comp_in), .synced(level)
    );

    fail_qualify #(.N(N), .CW(CW)) u_qual (
        .clk(clk), .rst_n(rst_n), .clr(clr), .hold_len(hold_len),
        .level(level), .excluded(fail_mask), .qualified(qualified)
    );

    fail_pick #(.N(N), .IW(IW)) u_pick (
        .req(qualified), .found(found), .idx(pick_idx)
    );

    always_comb begin
        accept  = 1'b0;
        state_d = state_q;
        unique case (state_q)
            ST_WATCH: begin
                if (clr) begin
                    state_d = ST_WATCH;
                end else if (found) begin
                    accept = 1'b1;
                    if (fail_count + 1'b1 >= FULL_CNT) state_d = ST_FULL;
                end
            end
            ST_FULL: begin
                if (clr) state_d = ST_WATCH;
            end
            default: state_d = ST_WATCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WATCH;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail_valid <= 1'b0;
            fail_idx   <= '0;
            fail_mask  <= '0;
            fail_count <= '0;
        end else if (clr) begin
            fail_valid <= 1'b0;
            fail_idx   <= '0;
            fail_mask  <= '0;
            fail_count <= '0;
        end else begin
            fail_valid <= accept;
            if (accept) begin
                fail_idx             <= pick_idx;
                fail_mask[pick_idx]  <= 1'b1;
                if (fail_count != FULL_CNT) fail_count <= fail_count + 1'b1;
            end
        end
    end

    for (genvar k = 0; k < N; k++) begin : g_log
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              log_q[k] <= '0;
            else if (clr)                            log_q[k] <= '0;
            else if (accept && fail_count == KW'(k)) log_q[k] <= pick_idx;
        end
        assign fail_log[k*IW +: IW] = log_q[k];
    end

    // R8
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_count <= FULL_CNT);

    // R8
    count_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_count == KW'($countones(fail_mask)));

    // R6
    mask_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr) |-> (($past(fail_mask) & ~fail_mask) == '0));

    // R4
    valid_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_valid |-> (fail_mask[fail_idx] &&
                        $countones(fail_mask ^ $past(fail_mask)) == 1));

    // R8
    full_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL) |=> !fail_valid);
endmodule

// File: tb/sim_fail_latch_top.sv
module sim_fail_latch_top;
    localparam int N = 8, CW = 8, IW = 3, KW = 4;

    logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
    logic [CW-1:0] hold_len = 8'd1;
    logic [N-1:0] comp_in = '0;
    logic fail_valid;
    logic [IW-1:0] fail_idx;
    logic [N-1:0] fail_mask;
    logic [KW-1:0] fail_count;
    logic [N*IW-1:0] fail_log;

    int tests = 0, fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    fail_latch_top #(.N(N), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .hold_len(hold_len),
        .comp_in(comp_in), .fail_valid(fail_valid), .fail_idx(fail_idx),
        .fail_mask(fail_mask), .fail_count(fail_count), .fail_log(fail_log)
    );

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic cleanup();
        @(negedge clk); comp_in = '0;
        repeat (4) step();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        step();
    endtask

    task automatic t_reset();
        check("R1 valid", fail_valid, 0);
        check("R1 mask", fail_mask, 0);
        check("R1 count", fail_count, 0);
        check("R1 log", int'(fail_log), 0);
        check("R1 idx", fail_idx, 0);
    endtask

    task automatic t_latency(int h, int bitn);
        int edges = 0;
        int hit = 0;
        @(negedge clk); hold_len = CW'(h); comp_in[bitn] = 1'b1;
        for (int e = 1; e <= h + 6; e++) begin
            step();
            if (fail_valid && hit == 0) begin hit = e; edges = e; end
        end
        check("R2 latency", edges, ((h == 0) ? 1 : h) + 2);
        check("R4 idx", fail_idx, bitn);
        check("R4 single pulse", fail_valid, 0);
        check("R6 mask bit", fail_mask[bitn], 1);
        check("R9 log slot0", int'(fail_log[IW-1:0]), bitn);
        cleanup();
    endtask

    task automatic t_glitch();
        int seen = 0;
        @(negedge clk); hold_len = 8'd4; comp_in[1] = 1'b1;
        repeat (3) @(negedge clk);
        comp_in[1] = 1'b0;
        for (int e = 0; e < 10; e++) begin step(); if (fail_valid) seen++; end
        check("R3 glitch ignored", seen, 0);
        check("R3 mask", fail_mask, 0);
        cleanup();
    endtask

    task automatic t_simul();
        @(negedge clk); hold_len = 8'd1; comp_in = 8'b0110_0100;
        for (int e = 0; e < 10 && !fail_valid; e++) step();
        check("R5 first", fail_idx, 2);
        step();
        check("R5 second valid", fail_valid, 1);
        check("R5 second", fail_idx, 5);
        step();
        check("R5 third", fail_idx, 6);
        step();
        check("R5 done", fail_valid, 0);
        check("R9 log order", int'(fail_log[3*IW-1:0]), (6 << 6) | (5 << 3) | 2);
        check("R8 count3", fail_count, 3);
        cleanup();
    endtask

    task automatic t_masked();
        int seen = 0;
        @(negedge clk); hold_len = 8'd1; comp_in[3] = 1'b1;
        repeat (6) step();
        check("R6 logged", fail_mask, 8'h08);
        for (int r = 0; r < 3; r++) begin
            @(negedge clk); comp_in[3] = 1'b0;
            repeat (3) begin step(); if (fail_valid) seen++; end
            @(negedge clk); comp_in[3] = 1'b1;
            repeat (5) begin step(); if (fail_valid) seen++; end
        end
        check("R7 no retrigger", seen, 0);
        check("R7 count", fail_count, 1);
        check("R7 mask", fail_mask, 8'h08);
        check("R7 log", int'(fail_log), 3);
        cleanup();
    endtask

    task automatic t_full_clear();
        int seen = 0;
        @(negedge clk); hold_len = 8'd2; comp_in = 8'hFF;
        repeat (16) step();
        check("R8 saturate", fail_count, N);
        check("R6 all masked", fail_mask, 8'hFF);
        for (int k = 0; k < N; k++)
            check("R9 slot", int'(fail_log[k*IW +: IW]), k);
        @(negedge clk); comp_in[0] = 1'b0;
        repeat (4) step();
        @(negedge clk); comp_in[0] = 1'b1;
        repeat (6) begin step(); if (fail_valid) seen++; end
        check("R8 full quiet", seen, 0);
        check("R8 still N", fail_count, N);
        @(negedge clk); comp_in = 8'h10; clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        #1;
        check("R10 count clr", fail_count, 0);
        check("R10 mask clr", fail_mask, 0);
        check("R10 log clr", int'(fail_log), 0);
        for (int e = 0; e < 8 && !fail_valid; e++) step();
        check("R10 redetect", fail_idx, 4);
        check("R10 recount", fail_count, 1);
        cleanup();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        step();
        t_latency(1, 0);
        t_latency(5, 7);
        t_latency(0, 4);
        t_glitch();
        t_simul();
        t_masked();
        t_full_clear();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule